// File: doc/BRIEF.md
# Raster Timing Generator with Position Counters

This block generates the horizontal and vertical timing of one display pipe from a set of programmable totals and thresholds. A horizontal counter walks every pixel clock of a line and a vertical counter walks the lines of a frame. From these two counters the block derives active, blank and sync levels, and it emits one-cycle event pulses for start of vertical blank, frame start and start of vertical sync. Next to the raster it keeps counters that software or a neighbouring block can read: a scanline position, a frame counter, a pixel counter and a frame timestamp.

Vertical events do not align with the start of a line. They fire at the leading edge of horizontal sync on the line before the threshold, and the scanline counter advances at that same edge. Frame start is placed at the start of horizontal blank, one to four lines after vertical blank begins. The timing inputs pass through a shadow copy. While the block runs, the copy reloads only at the start-of-vblank strobe. While the block is stopped, the copy follows the inputs on every clock, so a mode is loaded by holding `enable` low for at least one clock before starting.

The block has no data stream. All its pins are plain control and status signals, so no valid/ready handshake or back-pressure applies.

Top module: `disp_raster_timer`

## Requirements
- R1: While enabled, the horizontal counter runs from 0 to htotal-1. At the end of each line the vertical counter advances from 0 to vtotal-1 and then wraps. The pixel counter is 0 at the first pixel of line 0 and rises by one on every enabled clock.
- R2: `h_active` is high when the horizontal count is below hblank_start. `h_sync` is high from hsync_start to the end of the line. `v_active` is high when the vertical count is below vblank_start. `de` is `h_active` AND `v_active`.
- R3: Vertical levels use the sync-based line number. This number is the vertical count, plus one (modulo vtotal) once the horizontal count reaches hsync_start. `v_blank` is high when the sync-based line is at least vblank_start. `v_sync` is high when it lies in [vsync_start, vsync_end). `ev_vblank_start` pulses when the horizontal count equals hsync_start on line vblank_start-1. `ev_vsync_start` pulses when the horizontal count equals hsync_start on line vsync_start-1.
- R4: `scanline` is the sync-based line minus one, modulo vtotal. It reads vtotal-1 on line 0 before hsync and 0 after that hsync.
- R5: `ev_frame_start` pulses when the horizontal count equals hblank_start on line vblank_start+delay, where delay is the 2-bit `cfg_fs_delay` (0 to 3).
- R6: When `cfg_count_at_vblank`=1, `frame_count` increments on each start-of-vblank pulse. When it is 0, `frame_count` increments on the step into the first pixel of line 0.
- R7: `frame_count` is FCW bits wide (24 by default) and wraps from all ones to zero.
- R8: On each start-of-vblank pulse, `frame_ts` captures `ts_in`. The new value is visible after that clock edge.
- R9: While enabled, the active timing copy loads the `cfg_*` inputs only at the start-of-vblank edge. While disabled, it loads them on every clock.
- R10: While `enable` is low, the horizontal, vertical and pixel counters hold their values and no event pulse is produced.
- R11: Each event pulse lasts one clock. `status` bit 0 (vblank start), bit 1 (frame start) and bit 2 (vsync start) are sticky copies of the pulses. A 1 on the matching `status_clr` bit clears a status bit, but a pulse in the same clock wins over the clear.
- R12: After reset the counters, `frame_count`, `frame_ts`, `status` and the timing copy are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the raster; low freezes the counters and loads the timing copy |
| cfg_htotal | input | HW | Clocks per line |
| cfg_hblank_start | input | HW | First horizontal blank clock |
| cfg_hsync_start | input | HW | Horizontal sync leading edge |
| cfg_vtotal | input | VW | Lines per frame |
| cfg_vblank_start | input | VW | First blank line |
| cfg_vsync_start | input | VW | First vertical sync line |
| cfg_vsync_end | input | VW | First line after vertical sync |
| cfg_fs_delay | input | 2 | Extra frame-start delay in lines |
| cfg_count_at_vblank | input | 1 | Frame counter mode select |
| ts_in | input | TSW | Free-running timestamp |
| status_clr | input | 3 | Write-one-to-clear for status |
| h_active | output | 1 | Horizontal active level |
| h_sync | output | 1 | Horizontal sync level |
| v_active | output | 1 | Vertical active level |
| v_blank | output | 1 | Vertical blank level (sync-based) |
| v_sync | output | 1 | Vertical sync level (sync-based) |
| de | output | 1 | Display enable |
| ev_vblank_start | output | 1 | Start-of-vblank pulse and configuration latch strobe |
| ev_frame_start | output | 1 | Frame start pulse |
| ev_vsync_start | output | 1 | Start-of-vsync pulse |
| scanline | output | VW | Scanline counter |
| frame_count | output | FCW | Frame counter |
| pixel_count | output | HW+VW | Pixels since frame start |
| frame_ts | output | TSW | Timestamp captured at vblank start |
| status | output | 3 | Sticky event flags |

## Verification
The bench builds the block with HW=5, VW=4, FCW=3 and TSW=16. It uses a 10-by-8 raster of 80 clocks per frame and a second 12-by-9 raster for the shadow-reload test. Because frames are short, every pixel of every frame is compared against an arithmetic model. The 3-bit frame counter then wraps within eight frames, so the wrap is checked in a normal run. All four frame-start delays and both counting modes are run, along with a freeze, periodic status clears that sometimes collide with events, and a mid-frame mode change. That change must wait for the next vblank-start edge.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int NEV     = 3;
  localparam int EV_VBS  = 0;
  localparam int EV_FS   = 1;
  localparam int EV_VSS  = 2;
endpackage

// File: rtl/drt_shadow.sv
module drt_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/drt_raster.sv
module drt_raster #(
  parameter int HW = 12,
  parameter int VW = 11,
  localparam int PW = HW + VW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [HW-1:0] htotal,
  input  logic [VW-1:0] vtotal,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic [PW-1:0] pix,
  output logic          frame_end
);
  logic line_end;
  assign line_end  = (hcnt >= htotal - HW'(1));
  assign frame_end = line_end && (vcnt >= vtotal - VW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
      pix  <= '0;
    end else if (en) begin
      if (line_end) begin
        hcnt <= '0;
        vcnt <= frame_end ? '0 : vcnt + VW'(1);
      end else begin
        hcnt <= hcnt + HW'(1);
      end
      pix <= frame_end ? '0 : pix + PW'(1);
    end
  end

  // R10: frozen while disabled
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(hcnt) && $stable(vcnt) && $stable(pix)));
  // R1: pixel counter steps by one inside a frame
  a_r1_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_end) |=> pix == $past(pix) + PW'(1));
  // R1: frame end returns to the first pixel
  a_r1_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_end) |=> (hcnt == '0 && vcnt == '0 && pix == '0));
endmodule

// File: rtl/drt_events.sv
module drt_events #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic [HW-1:0] hblank_start,
  input  logic [HW-1:0] hsync_start,
  input  logic [VW-1:0] vtotal,
  input  logic [VW-1:0] vblank_start,
  input  logic [VW-1:0] vsync_start,
  input  logic [VW-1:0] vsync_end,
  input  logic [1:0]    fs_delay,
  output logic          h_active,
  output logic          h_sync,
  output logic          v_active,
  output logic          v_blank,
  output logic          v_sync,
  output logic          ev_vbs,
  output logic          ev_fs,
  output logic          ev_vss,
  output logic [VW-1:0] scanline
);
  logic [VW-1:0] vnext;
  logic [VW-1:0] vline;
  logic          at_hs_edge;

  assign vnext      = (vcnt >= vtotal - VW'(1)) ? '0 : vcnt + VW'(1);
  assign h_sync     = (hcnt >= hsync_start);
  assign vline      = h_sync ? vnext : vcnt;
  assign at_hs_edge = en && (hcnt == hsync_start);

  assign h_active = (hcnt < hblank_start);
  assign v_active = (vcnt < vblank_start);
  assign v_blank  = (vline >= vblank_start);
  assign v_sync   = (vline >= vsync_start) && (vline < vsync_end);
  assign scanline = (vline == '0) ? vtotal - VW'(1) : vline - VW'(1);

  assign ev_vbs = at_hs_edge && (vnext == vblank_start);
  assign ev_vss = at_hs_edge && (vnext == vsync_start);
  assign ev_fs  = en && (hcnt == hblank_start) &&
                  (vcnt == vblank_start + VW'(fs_delay));

  // R10: no pulses while stopped
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(ev_vbs || ev_fs || ev_vss));
  // R11: pulses are one clock wide
  a_r11_vbs_one: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vbs |=> !ev_vbs);
  a_r11_fs_one: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fs |=> !ev_fs);
  // R3: vblank start coincides with the blank level rising
  a_r3_vbs_level: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vbs |-> v_blank);
endmodule

// File: rtl/disp_raster_timer.sv
module disp_raster_timer
  import drt_pkg::*;
#(
  parameter int HW  = 12,
  parameter int VW  = 11,
  parameter int FCW = 24,
  parameter int TSW = 32,
  localparam int PW = HW + VW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [HW-1:0]  cfg_htotal,
  input  logic [HW-1:0]  cfg_hblank_start,
  input  logic [HW-1:0]  cfg_hsync_start,
  input  logic [VW-1:0]  cfg_vtotal,
  input  logic [VW-1:0]  cfg_vblank_start,
  input  logic [VW-1:0]  cfg_vsync_start,
  input  logic [VW-1:0]  cfg_vsync_end,
  input  logic [1:0]     cfg_fs_delay,
  input  logic           cfg_count_at_vblank,
  input  logic [TSW-1:0] ts_in,
  input  logic [NEV-1:0] status_clr,
  output logic           h_active,
  output logic           h_sync,
  output logic           v_active,
  output logic           v_blank,
  output logic           v_sync,
  output logic           de,
  output logic           ev_vblank_start,
  output logic           ev_frame_start,
  output logic           ev_vsync_start,
  output logic [VW-1:0]  scanline,
  output logic [FCW-1:0] frame_count,
  output logic [PW-1:0]  pixel_count,
  output logic [TSW-1:0] frame_ts,
  output logic [NEV-1:0] status
);
  localparam int CW = 3*HW + 4*VW + 3;

  logic [CW-1:0]  cfg_in, cfg_act;
  logic [HW-1:0]  a_ht, a_hb, a_hs;
  logic [VW-1:0]  a_vt, a_vb, a_vss, a_vse;
  logic [1:0]     a_dly;
  logic           a_mode;
  logic [HW-1:0]  hcnt;
  logic [VW-1:0]  vcnt;
  logic           frame_end;
  logic           fc_inc;
  logic [NEV-1:0] ev;

  assign cfg_in = {cfg_htotal, cfg_hblank_start, cfg_hsync_start, cfg_vtotal,
                   cfg_vblank_start, cfg_vsync_start, cfg_vsync_end,
                   cfg_fs_delay, cfg_count_at_vblank};
  assign {a_ht, a_hb, a_hs, a_vt, a_vb, a_vss, a_vse, a_dly, a_mode} = cfg_act;

  drt_shadow #(.W(CW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(!enable || ev_vblank_start),
    .d(cfg_in), .q(cfg_act)
  );

  drt_raster #(.HW(HW), .VW(VW)) u_raster (
    .clk(clk), .rst_n(rst_n), .en(enable), .htotal(a_ht), .vtotal(a_vt),
    .hcnt(hcnt), .vcnt(vcnt), .pix(pixel_count), .frame_end(frame_end)
  );

  drt_events #(.HW(HW), .VW(VW)) u_events (
    .clk(clk), .rst_n(rst_n), .en(enable), .hcnt(hcnt), .vcnt(vcnt),
    .hblank_start(a_hb), .hsync_start(a_hs), .vtotal(a_vt),
    .vblank_start(a_vb), .vsync_start(a_vss), .vsync_end(a_vse),
    .fs_delay(a_dly), .h_active(h_active), .h_sync(h_sync),
    .v_active(v_active), .v_blank(v_blank), .v_sync(v_sync),
    .ev_vbs(ev_vblank_start), .ev_fs(ev_frame_start),
    .ev_vss(ev_vsync_start), .scanline(scanline)
  );

  assign de = h_active && v_active;

  always_comb begin
    ev         = '0;
    ev[EV_VBS] = ev_vblank_start;
    ev[EV_FS]  = ev_frame_start;
    ev[EV_VSS] = ev_vsync_start;
  end

  assign fc_inc = a_mode ? ev_vblank_start : (enable && frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_count <= '0;
      frame_ts    <= '0;
      status      <= '0;
    end else begin
      if (fc_inc)          frame_count <= frame_count + FCW'(1);
      if (ev_vblank_start) frame_ts    <= ts_in;
      status <= (status & ~status_clr) | ev;
    end
  end

  // R8: timestamp captured at vblank start
  a_r8_ts_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vblank_start |=> frame_ts == $past(ts_in));
  // R7: counter wraps to zero
  a_r7_fc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_inc && frame_count == '1) |=> frame_count == '0);
  // R6: counter holds without an increment event
  a_r6_fc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_inc |=> $stable(frame_count));
  // R9: timing copy is held while running between strobes
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !ev_vblank_start) |=> $stable(cfg_act));
  // R11: uncleared status bits stay set
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & ~status_clr)) == $past(status & ~status_clr)));
endmodule

// File: tb/tb_disp_raster_timer.sv
module tb_disp_raster_timer;
  localparam int HW = 5, VW = 4, FCW = 3, TSW = 16, PW = HW + VW;

  logic clk = 1'b0;
  logic rst_n, enable, cfg_count_at_vblank;
  logic [HW-1:0] cfg_htotal, cfg_hblank_start, cfg_hsync_start;
  logic [VW-1:0] cfg_vtotal, cfg_vblank_start, cfg_vsync_start, cfg_vsync_end;
  logic [1:0] cfg_fs_delay;
  logic [TSW-1:0] ts_in;
  logic [2:0] status_clr;
  logic h_active, h_sync, v_active, v_blank, v_sync, de;
  logic ev_vblank_start, ev_frame_start, ev_vsync_start;
  logic [VW-1:0] scanline;
  logic [FCW-1:0] frame_count;
  logic [PW-1:0] pixel_count;
  logic [TSW-1:0] frame_ts;
  logic [2:0] status;

  int n_chk = 0, n_err = 0, n_tick = 0;
  int mh, mv, mpix, mfc, mts, mstat;
  int c_ht, c_hb, c_hs, c_vt, c_vb, c_vss, c_vse, c_dly, c_mode;

  always #10 clk = ~clk;

  disp_raster_timer #(.HW(HW), .VW(VW), .FCW(FCW), .TSW(TSW)) dut (.*);

  task automatic chk(input string req, input string nm, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d (tick %0d)", req, nm, act, exp, n_tick);
    end
  endtask

  task automatic drive_cfg(input int ht, hb, hs, vt, vb, vss, vse, dly, mode);
    cfg_htotal = HW'(ht); cfg_hblank_start = HW'(hb); cfg_hsync_start = HW'(hs);
    cfg_vtotal = VW'(vt); cfg_vblank_start = VW'(vb); cfg_vsync_start = VW'(vss);
    cfg_vsync_end = VW'(vse); cfg_fs_delay = 2'(dly); cfg_count_at_vblank = mode[0];
  endtask

  task automatic model_load();
    c_ht = int'(cfg_htotal); c_hb = int'(cfg_hblank_start); c_hs = int'(cfg_hsync_start);
    c_vt = int'(cfg_vtotal); c_vb = int'(cfg_vblank_start); c_vss = int'(cfg_vsync_start);
    c_vse = int'(cfg_vsync_end); c_dly = int'(cfg_fs_delay); c_mode = int'(cfg_count_at_vblank);
  endtask

  task automatic tick();
    int vl, sv, fs, vs, e;
    e  = int'(enable);
    vl = (mh >= c_hs) ? (mv + 1) % c_vt : mv;
    sv = e & int'(mh == c_hs && (mv + 1) % c_vt == c_vb);
    vs = e & int'(mh == c_hs && (mv + 1) % c_vt == c_vss);
    fs = e & int'(mh == c_hb && mv == c_vb + c_dly);
    chk("R2", "h_active", int'(h_active), int'(mh < c_hb));
    chk("R2", "h_sync", int'(h_sync), int'(mh >= c_hs));
    chk("R2", "v_active", int'(v_active), int'(mv < c_vb));
    chk("R2", "de", int'(de), int'(mh < c_hb && mv < c_vb));
    chk("R3", "v_blank", int'(v_blank), int'(vl >= c_vb));
    chk("R3", "v_sync", int'(v_sync), int'(vl >= c_vss && vl < c_vse));
    chk("R3", "ev_vblank_start", int'(ev_vblank_start), sv);
    chk("R3", "ev_vsync_start", int'(ev_vsync_start), vs);
    chk("R5", "ev_frame_start", int'(ev_frame_start), fs);
    chk("R4", "scanline", int'(scanline), (vl + c_vt - 1) % c_vt);
    chk("R1", "pixel_count", int'(pixel_count), mpix);
    chk("R6", "frame_count", int'(frame_count), mfc);
    chk("R8", "frame_ts", int'(frame_ts), mts);
    chk("R11", "status", int'(status), mstat);
    ts_in = ts_in + TSW'(3);
    if (e == 1) begin
      if ((c_mode == 1) ? (sv == 1) : (mh == c_ht - 1 && mv == c_vt - 1))
        mfc = (mfc + 1) % (1 << FCW);
      if (sv == 1) mts = int'(ts_in);
      if (mh == c_ht - 1) begin
        mh = 0;
        mv = (mv == c_vt - 1) ? 0 : mv + 1;
      end else mh = mh + 1;
      mpix = (mh == 0 && mv == 0) ? 0 : mpix + 1;
      if (sv == 1) model_load();
    end else model_load();
    mstat = (mstat & ~int'(status_clr)) | sv | (fs << 1) | (vs << 2);
    n_tick++;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      status_clr = ((n_tick % 13) == 12) ? 3'b111 : 3'b000;
      tick();
    end
    status_clr = 3'b000;
  endtask

  task automatic do_reset(input int dly, input int mode);
    rst_n = 1'b0; enable = 1'b0; status_clr = '0;
    drive_cfg(10, 7, 8, 8, 5, 6, 7, dly, mode);
    @(negedge clk); @(negedge clk);
    chk("R12", "status_in_reset", int'(status), 0);
    chk("R12", "frame_ts_in_reset", int'(frame_ts), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mh = 0; mv = 0; mpix = 0; mfc = 0; mts = 0; mstat = 0;
    model_load();
    chk("R12", "pixel_count_reset", int'(pixel_count), 0);
    chk("R12", "frame_count_reset", int'(frame_count), 0);
    chk("R4", "scanline_first_line", int'(scanline), 7);
  endtask

  initial begin
    ts_in = TSW'(100);
    // main sweep: frame-end counting, wrap of the 3-bit counter (R7)
    do_reset(0, 0);
    enable = 1'b1;
    run(10 * 80 + 5);
    chk("R7", "frame_count_wrapped", int'(frame_count), (10 % 8));
    // freeze (R10): pulses and counters must hold
    run(17);
    enable = 1'b0;
    run(6);
    chk("R10", "pixel_after_freeze", int'(pixel_count), mpix);
    enable = 1'b1;
    run(200);
    // all frame-start delays with vblank counting mode (R5, R6)
    for (int d = 0; d < 4; d++) begin
      do_reset(d, 1);
      enable = 1'b1;
      run(2 * 80 + 30);
      chk("R6", "frame_count_vblank_mode", int'(frame_count), 2);
    end
    // shadow reload mid-frame (R9)
    do_reset(1, 0);
    enable = 1'b1;
    run(12);
    drive_cfg(12, 9, 10, 9, 6, 7, 8, 2, 0);
    run(20);
    chk("R9", "old_timing_kept", int'(h_sync), int'(mh >= 8));
    run(3 * 108 + 40);
    // explicit clear colliding with nothing (R11)
    enable = 1'b0;
    status_clr = 3'b111;
    tick();
    status_clr = 3'b000;
    chk("R11", "status_cleared", int'(status), 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule